// File: doc/BRIEF.md
# Processor Bus Cycle Sequencer

This block runs one external bus machine cycle at a time on behalf of a processor. A request carries an address, write data, a transfer direction, a memory-or-IO select and an operand-or-instruction select. The block registers these, raises an active-high address strobe, and then lowers an active-low data strobe. It also lowers either a read strobe or a write strobe. The cycle is stretched by whole clock periods for as long as the active-low ready input stays high. It closes on the clock edge where ready is seen low. On a read, the returned data is captured on that same edge.

A slow timer clock, nominally 100 kHz, guards against a device that never answers. The system clock must run at least nine times faster than the timer clock. The timer clock is brought into the system clock domain and its falling edges are counted while the data strobe is low and ready is high. If two such edges arrive, the cycle is forced to end, an error pulse is given and a sticky fault bit is set. The fault bit stays set until it is cleared. A disable input suppresses this timeout. A float input tells the external drivers to release the bus while the block is idle, and blocks any new cycle from starting.

Top module: `bus_cycle_seq`

## Requirements
- R1: After a clock edge with `rst_n` low, the sequencer is idle. `as_o` is 0, `ds_n_o`, `rd_n_o` and `wr_n_o` are 1, `done_o`, `err_o` and `fault_o` are 0, and the registered address, data and attribute outputs are 0.
- R2: A request seen while idle, with `float_i` low, raises `as_o` on the next clock. `addr_o`, `wdata_o`, `rd_o` (1 = read, 0 = write), `mem_o` (1 = memory, 0 = IO) and `opr_o` (1 = operand, 0 = instruction) show the request's values from that clock and hold them until the next cycle is accepted. Requests made while a cycle is in progress are ignored.
- R3: One clock after `as_o` rises, `ds_n_o` goes low. Together with it, `rd_n_o` goes low on a read or `wr_n_o` goes low on a write, and the other strobe stays high. `ds_n_o` is only low while `as_o` is high.
- R4: While `rdy_n_i` is sampled high in the data phase, all strobes hold (wait states). On the edge where `rdy_n_i` is sampled low, `as_o` falls and `ds_n_o`, `rd_n_o` and `wr_n_o` return high.
- R5: On a read, `rdata_o` takes `rdata_i` on the edge that ends the cycle because ready was low, and holds that value until the next read completes.
- R6: In the clock after a cycle ends, exactly one of `done_o` (ready-ended) or `err_o` (timeout-ended) is high, for one clock. The sequencer is then idle again.
- R7: If two falling edges of `tclk_i`, synchronized into the clock domain, occur while the data strobe is low and ready is high, the cycle is terminated. `err_o` pulses and `fault_o` becomes 1.
- R8: While `to_dis_i` is high, no timeout ends a cycle. A cycle in which ready stays high for many timer periods ends normally once ready goes low.
- R9: `fault_o` stays 1 across later cycles until `fault_clr_i` is sampled high. A new timeout on the same edge wins over the clear.
- R10: While idle with `float_i` high, `bus_drive_o` is 0 and requests start no cycle. Otherwise `bus_drive_o` is 1.
- R11: The timeout count restarts at the start of every data phase, so timer edges seen in earlier cycles never add up toward a timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Start a bus cycle (taken when idle) |
| float_i | input | 1 | Release the bus while idle, block new cycles |
| addr_i | input | AW | Cycle address |
| wdata_i | input | DW | Write data |
| rd_i | input | 1 | Direction: 1 read, 0 write |
| mem_i | input | 1 | Space: 1 memory, 0 IO |
| opr_i | input | 1 | Access: 1 operand, 0 instruction |
| rdata_i | input | DW | Read data from the bus |
| rdy_n_i | input | 1 | Active-low ready |
| tclk_i | input | 1 | Slow timer clock (asynchronous) |
| to_dis_i | input | 1 | Suppress bus timeout |
| fault_clr_i | input | 1 | Clear the timeout fault bit |
| bus_drive_o | output | 1 | High when the external drivers should drive the bus |
| as_o | output | 1 | Address strobe, active high |
| ds_n_o | output | 1 | Data strobe, active low |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| addr_o | output | AW | Registered cycle address |
| wdata_o | output | DW | Registered write data |
| rd_o | output | 1 | Registered direction |
| mem_o | output | 1 | Registered memory/IO select |
| opr_o | output | 1 | Registered operand/instruction select |
| rdata_o | output | DW | Captured read data |
| done_o | output | 1 | One-clock pulse: cycle ended by ready |
| err_o | output | 1 | One-clock pulse: cycle ended by timeout |
| fault_o | output | 1 | Sticky bus timeout fault |

## Verification
The bench targets three timeout cases: a stalled cycle that must end on the second timer fall, a cycle that stalls with the timeout disabled, and a chain of cycles that each see only one timer fall. A design that counts core clocks, or that ignores the disable input, would end on the wrong clock or raise `err_o`. A counter that is not cleared per data phase would report a timeout in the chain. The bench also pokes a request into a busy cycle and changes `addr_i`, which a design without an idle check would restart on. It checks that `fault_o` survives a later good cycle, where a non-sticky bit would drop. It raises `float_i` with a pending request, which a design without that block would act on.

// File: rtl/bcs_pkg.sv
// Shared types for the bus cycle sequencer.
// Assumes: one cycle in flight at a time.
package bcs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2,
        ST_END  = 2'd3
    } bcs_state_e;

    typedef struct packed {
        logic rd;
        logic mem;
        logic opr;
    } bcs_attr_t;

endpackage

// File: rtl/bcs_tclk_edge.sv
// Brings the asynchronous timer clock into the system clock domain and
// emits a one-clock pulse for each falling edge.
// Assumes: the system clock runs at least nine times the timer clock,
// so no timer level is shorter than a few system clocks.
module bcs_tclk_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tclk_i,
    output logic fall_o
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    // Shift the timer level through the synchronizer and keep one older copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], tclk_i};
            last_q <= sync_q[STAGES-1];
        end
    end

    // High-to-low on the synchronized level.
    assign fall_o = last_q & ~sync_q[STAGES-1];

endmodule

// File: rtl/bcs_timeout.sv
// Counts timer-clock falls seen while a data phase waits for ready.
// Saturates at the limit and raises hit_o there.
// Assumes: arm_i is low outside the data phase, which clears the count.
module bcs_timeout #(
    parameter int TO_FALLS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic rdy_n_i,
    input  logic fall_i,
    output logic hit_o
);
    localparam int CW = $clog2(TO_FALLS + 1);

    logic [CW-1:0] cnt_q;

    // Clear outside the data phase, count falls while ready is withheld.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!arm_i) begin
            cnt_q <= '0;
        end else if (fall_i && rdy_n_i && (cnt_q != CW'(TO_FALLS))) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign hit_o = (cnt_q == CW'(TO_FALLS));

endmodule

// File: rtl/bcs_fsm.sv
// State machine for one bus cycle: accept, address phase, data phase with
// wait states, end. Owns the registered request, read capture and fault bit.
// Assumes: to_hit_i comes from a counter that is cleared whenever the
// state is not ST_DATA.
module bcs_fsm
    import bcs_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    input  logic          float_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    input  bcs_attr_t     attr_i,
    input  logic [DW-1:0] rdata_i,
    input  logic          rdy_n_i,
    input  logic          to_hit_i,
    input  logic          to_dis_i,
    input  logic          fault_clr_i,
    output logic          in_data_o,
    output logic          bus_drive_o,
    output logic          as_o,
    output logic          ds_n_o,
    output logic          rd_n_o,
    output logic          wr_n_o,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] wdata_o,
    output bcs_attr_t     attr_o,
    output logic [DW-1:0] rdata_o,
    output logic          done_o,
    output logic          err_o,
    output logic          fault_o
);
    bcs_state_e    st_q, st_d;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic [DW-1:0] rdata_q;
    bcs_attr_t     attr_q;
    logic          err_q;
    logic          fault_q;
    logic          accept;
    logic          rdy_end;
    logic          to_end;

    assign accept  = (st_q == ST_IDLE) && req_i && !float_i;
    assign rdy_end = (st_q == ST_DATA) && !rdy_n_i;
    assign to_end  = (st_q == ST_DATA) && rdy_n_i && to_hit_i && !to_dis_i;

    // Next-state selection.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (accept) st_d = ST_ADDR;
            ST_ADDR: st_d = ST_DATA;
            ST_DATA: if (rdy_end || to_end) st_d = ST_END;
            ST_END:  st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // State, request capture, read capture and end reason.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
            attr_q  <= '0;
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            st_q <= st_d;
            if (accept) begin
                addr_q  <= addr_i;
                wdata_q <= wdata_i;
                attr_q  <= attr_i;
            end
            if (rdy_end && attr_q.rd) begin
                rdata_q <= rdata_i;
            end
            if (st_q == ST_DATA) begin
                err_q <= to_end;
            end
        end
    end

    // Sticky fault: a timeout sets it, the clear input drops it, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_q <= 1'b0;
        end else if (to_end) begin
            fault_q <= 1'b1;
        end else if (fault_clr_i) begin
            fault_q <= 1'b0;
        end
    end

    assign in_data_o   = (st_q == ST_DATA);
    assign bus_drive_o = !(float_i && (st_q == ST_IDLE));
    assign as_o        = (st_q == ST_ADDR) || (st_q == ST_DATA);
    assign ds_n_o      = !(st_q == ST_DATA);
    assign rd_n_o      = !((st_q == ST_DATA) && attr_q.rd);
    assign wr_n_o      = !((st_q == ST_DATA) && !attr_q.rd);
    assign addr_o      = addr_q;
    assign wdata_o     = wdata_q;
    assign attr_o      = attr_q;
    assign rdata_o     = rdata_q;
    assign done_o      = (st_q == ST_END) && !err_q;
    assign err_o       = (st_q == ST_END) && err_q;
    assign fault_o     = fault_q;

endmodule

// File: rtl/bus_cycle_seq.sv
// Top of the bus cycle sequencer: joins the timer-edge detector, the
// timeout counter and the cycle state machine.
// Assumes: clk is at least nine times tclk_i; tclk_i is asynchronous.
module bus_cycle_seq
    import bcs_pkg::*;
#(
    parameter int AW          = 16,
    parameter int DW          = 16,
    parameter int TO_FALLS    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    input  logic          float_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          rd_i,
    input  logic          mem_i,
    input  logic          opr_i,
    input  logic [DW-1:0] rdata_i,
    input  logic          rdy_n_i,
    input  logic          tclk_i,
    input  logic          to_dis_i,
    input  logic          fault_clr_i,
    output logic          bus_drive_o,
    output logic          as_o,
    output logic          ds_n_o,
    output logic          rd_n_o,
    output logic          wr_n_o,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] wdata_o,
    output logic          rd_o,
    output logic          mem_o,
    output logic          opr_o,
    output logic [DW-1:0] rdata_o,
    output logic          done_o,
    output logic          err_o,
    output logic          fault_o
);
    logic      tfall;
    logic      to_hit;
    logic      in_data;
    bcs_attr_t attr_in;
    bcs_attr_t attr_out;

    assign attr_in = '{rd: rd_i, mem: mem_i, opr: opr_i};

    bcs_tclk_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .tclk_i (tclk_i),
        .fall_o (tfall)
    );

    bcs_timeout #(.TO_FALLS(TO_FALLS)) u_to (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm_i   (in_data),
        .rdy_n_i (rdy_n_i),
        .fall_i  (tfall),
        .hit_o   (to_hit)
    );

    bcs_fsm #(.AW(AW), .DW(DW)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req_i),
        .float_i     (float_i),
        .addr_i      (addr_i),
        .wdata_i     (wdata_i),
        .attr_i      (attr_in),
        .rdata_i     (rdata_i),
        .rdy_n_i     (rdy_n_i),
        .to_hit_i    (to_hit),
        .to_dis_i    (to_dis_i),
        .fault_clr_i (fault_clr_i),
        .in_data_o   (in_data),
        .bus_drive_o (bus_drive_o),
        .as_o        (as_o),
        .ds_n_o      (ds_n_o),
        .rd_n_o      (rd_n_o),
        .wr_n_o      (wr_n_o),
        .addr_o      (addr_o),
        .wdata_o     (wdata_o),
        .attr_o      (attr_out),
        .rdata_o     (rdata_o),
        .done_o      (done_o),
        .err_o       (err_o),
        .fault_o     (fault_o)
    );

    assign rd_o  = attr_out.rd;
    assign mem_o = attr_out.mem;
    assign opr_o = attr_out.opr;

endmodule

// File: rtl/bcs_checker.sv
// Port-level properties of the bus cycle sequencer, bound to its top.
// Assumes: synchronous active-low reset; all checks are off during reset.
module bcs_checker #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          float_i,
    input logic          rdy_n_i,
    input logic          to_dis_i,
    input logic          as_o,
    input logic          ds_n_o,
    input logic          rd_n_o,
    input logic          wr_n_o,
    input logic [AW-1:0] addr_o,
    input logic          rd_o,
    input logic          mem_o,
    input logic          opr_o,
    input logic          done_o,
    input logic          err_o,
    input logic          fault_o
);
    // Exactly one of read or write strobe accompanies the data strobe.
    p_one_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ds_n_o |-> (rd_n_o ^ wr_n_o));

    // Data strobe only inside the address strobe window.
    p_ds_in_as_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ds_n_o |-> as_o);

    // Registered request fields hold through the cycle.
    p_attr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (as_o && $past(as_o)) |-> ($stable(addr_o) && $stable(rd_o)
                                   && $stable(mem_o) && $stable(opr_o)));

    // Ready sampled low in the data phase closes the cycle on that edge.
    p_ready_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ds_n_o && !rdy_n_i) |=> (ds_n_o && !as_o));

    // Normal and timeout completion never coincide.
    p_outcome_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && err_o));

    // A timeout ending always leaves the fault bit set.
    p_err_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> fault_o);

    // Disabled timeout never produces an error ending.
    p_dis_no_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (to_dis_i && !ds_n_o) |=> !err_o);

    // A cycle never starts from a request made while floating.
    p_float_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(as_o) |-> $past(!float_i));

endmodule

bind bus_cycle_seq bcs_checker #(.AW(AW)) u_bcs_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .float_i  (float_i),
    .rdy_n_i  (rdy_n_i),
    .to_dis_i (to_dis_i),
    .as_o     (as_o),
    .ds_n_o   (ds_n_o),
    .rd_n_o   (rd_n_o),
    .wr_n_o   (wr_n_o),
    .addr_o   (addr_o),
    .rd_o     (rd_o),
    .mem_o    (mem_o),
    .opr_o    (opr_o),
    .done_o   (done_o),
    .err_o    (err_o),
    .fault_o  (fault_o)
);

// File: tb/bus_cycle_seq_test.sv
// Bench: a behavioural per-clock model compared with the outputs on every
// falling clock edge, plus directed scenarios with named checks.
module bus_cycle_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, flt = 1'b0, rd = 1'b1, mem = 1'b1, opr = 1'b0;
    logic        rdy_n = 1'b1, tclk = 1'b0, dis = 1'b0, clr = 1'b0;
    logic [15:0] addr = '0, wdata = '0, rdata_in = '0;

    logic        bus_drive, as_s, ds_n, rd_n, wr_n, rd_s, mem_s, opr_s;
    logic        done, err, fault;
    logic [15:0] addr_s, wdata_s, rdata_s;

    int n_chk = 0, n_fail = 0;
    bit cmp_en = 1'b0;

    bus_cycle_seq uut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .float_i(flt),
        .addr_i(addr), .wdata_i(wdata), .rd_i(rd), .mem_i(mem), .opr_i(opr),
        .rdata_i(rdata_in), .rdy_n_i(rdy_n), .tclk_i(tclk), .to_dis_i(dis),
        .fault_clr_i(clr), .bus_drive_o(bus_drive), .as_o(as_s),
        .ds_n_o(ds_n), .rd_n_o(rd_n), .wr_n_o(wr_n), .addr_o(addr_s),
        .wdata_o(wdata_s), .rd_o(rd_s), .mem_o(mem_s), .opr_o(opr_s),
        .rdata_o(rdata_s), .done_o(done), .err_o(err), .fault_o(fault)
    );

    always #10 clk = ~clk;

    // Timer clock: ten system clocks per level.
    int tdiv = 0;
    always @(negedge clk) begin
        tdiv++;
        if (tdiv == 10) begin
            tdiv = 0;
            tclk = ~tclk;
        end
    end

    task automatic chk(input string req_tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req_tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Reference model: phase 0 idle, 1 address, 2 data, 3 end.
    int          ph = 0;
    int          m_cnt = 0;
    logic [15:0] m_addr = '0, m_wdata = '0, m_rdata = '0;
    logic        m_rd = 0, m_mem = 0, m_opr = 0, m_errf = 0, m_fault = 0;
    logic        s1 = 0, s2 = 0, s3 = 0;

    always @(posedge clk) begin
        logic f;
        logic set_now;
        f = s3 && !s2;
        set_now = 1'b0;
        if (!rst_n) begin
            ph = 0; m_cnt = 0; m_addr = '0; m_wdata = '0; m_rdata = '0;
            m_rd = 0; m_mem = 0; m_opr = 0; m_errf = 0; m_fault = 0;
            s1 = 0; s2 = 0; s3 = 0;
        end else begin
            s3 = s2; s2 = s1; s1 = tclk;
            case (ph)
                0: if (req && !flt) begin
                    m_addr = addr; m_wdata = wdata;
                    m_rd = rd; m_mem = mem; m_opr = opr; ph = 1;
                end
                1: begin ph = 2; m_cnt = 0; end
                2: if (!rdy_n) begin
                    if (m_rd) m_rdata = rdata_in;
                    m_errf = 0; ph = 3;
                end else if (m_cnt >= 2 && !dis) begin
                    m_errf = 1; m_fault = 1; set_now = 1; ph = 3;
                end else if (f && m_cnt < 2) begin
                    m_cnt++;
                end
                default: ph = 0;
            endcase
            if (!set_now && clr) m_fault = 0;
        end
    end

    // Per-clock comparison of every output against the model.
    always @(negedge clk) begin
        if (cmp_en) begin
            chk("R2", "as_o", as_s, (ph == 1 || ph == 2));
            chk("R3", "ds_n_o", ds_n, !(ph == 2));
            chk("R3", "rd_n_o", rd_n, !(ph == 2 && m_rd));
            chk("R4", "wr_n_o", wr_n, !(ph == 2 && !m_rd));
            chk("R2", "addr_o", addr_s, m_addr);
            chk("R2", "wdata_o", wdata_s, m_wdata);
            chk("R2", "attrs", {rd_s, mem_s, opr_s}, {m_rd, m_mem, m_opr});
            chk("R5", "rdata_o", rdata_s, m_rdata);
            chk("R6", "done_o", done, (ph == 3 && !m_errf));
            chk("R7", "err_o", err, (ph == 3 && m_errf));
            chk("R9", "fault_o", fault, m_fault);
            chk("R10", "bus_drive_o", bus_drive, !(flt && ph == 0));
        end
    end

    // Watchdog.
    int wd = 0;
    always @(negedge clk) begin
        wd++;
        if (wd > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            finish_run();
        end
    end

    // One cycle: waits < 0 never gives ready; poke injects a busy request.
    task automatic run_cycle(input logic r, input logic m, input logic o,
                             input logic [15:0] a, input logic [15:0] w,
                             input logic [15:0] rdv, input int waits,
                             input bit poke, output bit got_err);
        bit seen = 0;
        int n = 0;
        got_err = 0;
        @(negedge clk); #2;
        req = 1; rd = r; mem = m; opr = o; addr = a; wdata = w;
        rdata_in = rdv; rdy_n = 1;
        @(negedge clk); #2;
        req = 0;
        for (int k = 0; k < 400 && !seen; k++) begin
            @(negedge clk);
            if (done || err) begin
                got_err = err;
                seen = 1;
            end else if (!ds_n) begin
                #2;
                req = 0;
                if (poke && n == 2) begin
                    req = 1; addr = a ^ 16'hFFFF;
                end
                if (n == waits) rdy_n = 0;
                n++;
            end
        end
        #2;
        rdy_n = 1; req = 0;
        if (!seen) chk("R6", "cycle finished", 0, 1);
    endtask

    initial begin
        bit e;
        repeat (3) @(negedge clk);
        #2 rst_n = 1;
        @(negedge clk);
        cmp_en = 1;
        // R1: reset state
        chk("R1", "reset as_o", as_s, 0);
        chk("R1", "reset strobes", {ds_n, rd_n, wr_n}, 3'b111);
        chk("R1", "reset flags", {done, err, fault}, 3'b000);
        chk("R1", "reset addr_o", addr_s, 0);

        // Read, memory, operand, no wait states.
        run_cycle(1, 1, 1, 16'h1234, 16'h0, 16'hBEEF, 0, 0, e);
        chk("R6", "read no-wait ends normally", e, 0);
        chk("R5", "read data captured", rdata_s, 16'hBEEF);

        // Write, IO, instruction, three wait states.
        run_cycle(0, 0, 0, 16'h00F0, 16'hA55A, 16'h1111, 3, 0, e);
        chk("R4", "write with waits ends normally", e, 0);
        chk("R5", "write leaves rdata_o", rdata_s, 16'hBEEF);
        chk("R2", "write data held", wdata_s, 16'hA55A);

        // Read with five waits plus a request poked while busy.
        run_cycle(1, 0, 1, 16'h8001, 16'h0, 16'h7E7E, 5, 1, e);
        chk("R4", "read with waits ends normally", e, 0);
        repeat (3) @(negedge clk);
        chk("R2", "busy request ignored: no new cycle", as_s, 0);
        chk("R2", "busy request ignored: address kept", addr_s, 16'h8001);

        // Float with a pending request.
        @(negedge clk); #2;
        flt = 1; req = 1; addr = 16'h4444;
        repeat (4) @(negedge clk);
        chk("R10", "float blocks request", as_s, 0);
        chk("R10", "float releases bus", bus_drive, 0);
        #2 req = 0; flt = 0;
        @(negedge clk);
        chk("R10", "drive restored", bus_drive, 1);

        // Timeout: ready never given.
        run_cycle(1, 1, 1, 16'h0BAD, 16'h0, 16'h0, -1, 0, e);
        chk("R7", "stalled cycle ends by timeout", e, 1);
        chk("R7", "fault set", fault, 1);

        // Sticky fault across a good cycle.
        run_cycle(0, 1, 1, 16'h0010, 16'h0202, 16'h0, 1, 0, e);
        chk("R9", "good cycle after fault", e, 0);
        chk("R9", "fault sticky", fault, 1);
        @(negedge clk); #2 clr = 1;
        @(negedge clk); #2 clr = 0;
        @(negedge clk);
        chk("R9", "fault cleared", fault, 0);

        // Timeout disabled: long stall ends normally.
        dis = 1;
        run_cycle(1, 1, 0, 16'h2222, 16'h0, 16'hC3C3, 60, 0, e);
        chk("R8", "disabled timeout ends normally", e, 0);
        chk("R8", "no fault while disabled", fault, 0);
        dis = 0;

        // Chain of cycles each spanning at most one timer fall.
        for (int i = 0; i < 6; i++) begin
            run_cycle(i[0], 1, 1, 16'h3000 + 16'(i), 16'(i), 16'h5A00 + 16'(i), 12, 0, e);
            chk("R11", "count restarts per cycle", e, 0);
        end
        chk("R11", "no fault after chain", fault, 0);

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule